// File: doc/BRIEF.md
# Multi-Channel Conversion Sequencer

This block decides which input channel a multiplexed converter works on and how long each conversion runs. An eight-bit enable mask chooses the channels that take part. The block visits them one after another in ascending index order, and it wraps around after the highest enabled channel. Every visit lasts one full settling interval. The length of that interval comes from a 10-bit settle word multiplied by a fixed number of clock cycles per word unit. When the interval ends, the block latches the sample presented on its data input along with the channel index. It then pulses a ready strobe for one cycle and starts on the next enabled channel in the same cycle.

Conversion runs continuously from reset. Holding the active-low sync input low freezes the sequence and suppresses the strobe. Once sync is released, the sequence starts over from the lowest enabled channel with a fresh settling interval. If the reference-valid input is low when a result is latched, the result is forced to all ones and a no-reference flag is raised. The mask is only read at a channel boundary.

Top module: `conv_seq`

## Requirements
- R1: While rst_ni is low, ready_o, noref_o, result_o and result_ch_o are all 0.
- R2: The enabled channels (bit k of chan_en_i enables channel k) are converted in ascending index order, wrapping from the highest enabled channel back to the lowest. After a reset or a sync release, the first channel is the lowest enabled one.
- R3: A settling interval lasts N = settle_word_i × UNIT_CYCLES clock cycles. The first strobe follows the N-th rising edge after the first edge at which sync_ni is sampled high. Later strobes come every N cycles.
- R4: A settle word of 0 is treated as 1.
- R5: On each strobe, result_o holds the value of sample_i sampled at the closing edge, and result_ch_o holds the index of the channel that just finished.
- R6: If ref_ok_i is low at the closing edge, result_o is 24'hFFFFFF and noref_o is 1. noref_o returns to 0 on the next result latched while ref_ok_i is high.
- R7: While sync_ni is low, no strobe occurs and ready_o is 0 from the next cycle on. After release, the sequence restarts as in R2 and R3.
- R8: With an all-zero mask the block idles and gives no strobe. When a bit is then set, conversion starts on the first clock edge and the first strobe follows N edges later.
- R9: A mask change during a settling interval does not affect the channel in progress. The next channel is picked from the new mask at the boundary.
- R10: ready_o is high for exactly one cycle per result when UNIT_CYCLES is at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_ni | input | 1 | Synchronous hold; low restarts the sequence |
| chan_en_i | input | 8 | Channel enable mask |
| settle_word_i | input | 10 | Settling length in word units |
| ref_ok_i | input | 1 | Reference valid |
| sample_i | input | 24 | Mock converter sample |
| result_o | output | 24 | Latched result |
| result_ch_o | output | 3 | Channel index of result_o |
| ready_o | output | 1 | One-cycle result strobe |
| noref_o | output | 1 | Last result taken with an invalid reference |

## Verification
The mask patterns used are sparse (0xA5), a single bit, two adjacent bits, and zero. Together they distinguish true rotation with wrap-around from fixed-order scanning or repeating one channel. Settle words of 0, 1, 2 and 3 expose off-by-one errors in the interval length, both for the first strobe and for the steady-state period. Dropping sync mid-sequence, changing the mask during a settling interval, and toggling the reference flag each show whether the restart point, the boundary sampling of the mask and the saturation flag are right.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic {
    SEQ_IDLE,
    SEQ_SETTLE
  } seq_state_e;
endpackage

// File: rtl/seq_next_pick.sv
module seq_next_pick #(
  parameter int NCH  = 8,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic [NCH-1:0]  mask_i,
  input  logic [CH_W-1:0] cur_i,
  output logic            found_o,
  output logic [CH_W-1:0] next_o
);
  // search from cur+NCH down to cur+1 so the nearest successor wins
  always_comb begin
    found_o = 1'b0;
    next_o  = cur_i;
    for (int i = NCH; i >= 1; i--) begin
      if (mask_i[(int'(cur_i) + i) % NCH]) begin
        found_o = 1'b1;
        next_o  = CH_W'((int'(cur_i) + i) % NCH);
      end
    end
  end
endmodule

// File: rtl/seq_settle_timer.sv
module seq_settle_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      run_q <= 1'b1;
    end else if (run_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = run_q && (cnt_q == '0);

  assert_done_holds_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q != '0 && !clr_i && !load_i) |=> run_q);
endmodule

// File: rtl/seq_capture.sv
module seq_capture #(
  parameter int DATA_W = 24,
  parameter int CH_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              fire_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              ref_ok_i,
  output logic [DATA_W-1:0] result_o,
  output logic [CH_W-1:0]   result_ch_o,
  output logic              ready_o,
  output logic              noref_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o    <= '0;
      result_ch_o <= '0;
      ready_o     <= 1'b0;
      noref_o     <= 1'b0;
    end else if (hold_i) begin
      ready_o <= 1'b0;
    end else begin
      ready_o <= fire_i;
      if (fire_i) begin
        result_o    <= ref_ok_i ? sample_i : '1;
        result_ch_o <= ch_i;
        noref_o     <= !ref_ok_i;
      end
    end
  end

  assert_noref_saturates_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && noref_o) |-> (result_o == '1));
endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import conv_seq_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int WORD_W      = 10,
  parameter int DATA_W      = 24,
  parameter int UNIT_CYCLES = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sync_ni,
  input  logic [NCH-1:0]           chan_en_i,
  input  logic [WORD_W-1:0]        settle_word_i,
  input  logic                     ref_ok_i,
  input  logic [DATA_W-1:0]        sample_i,
  output logic [DATA_W-1:0]        result_o,
  output logic [$clog2(NCH)-1:0]   result_ch_o,
  output logic                     ready_o,
  output logic                     noref_o
);
  localparam int CH_W  = $clog2(NCH);
  localparam int CNT_W = WORD_W + $clog2(UNIT_CYCLES + 1);

  seq_state_e       state_q;
  logic [CH_W-1:0]  cur_q;
  logic [CH_W-1:0]  next_ch;
  logic             found;
  logic             done;
  logic             load;
  logic             fire;
  logic             clr;
  logic [CNT_W-1:0] load_val;
  logic [WORD_W-1:0] eff_word;

  seq_next_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
    .mask_i (chan_en_i),
    .cur_i  (cur_q),
    .found_o(found),
    .next_o (next_ch)
  );

  assign eff_word = (settle_word_i == '0) ? WORD_W'(1) : settle_word_i;
  assign load_val = CNT_W'(eff_word) * CNT_W'(UNIT_CYCLES) - CNT_W'(1);

  assign fire = sync_ni && (state_q == SEQ_SETTLE) && done;
  assign load = sync_ni && found && ((state_q == SEQ_IDLE) || fire);
  assign clr  = !sync_ni || (fire && !found);

  seq_settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .load_i    (load),
    .load_val_i(load_val),
    .done_o    (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cur_q   <= CH_W'(NCH - 1);
    end else if (!sync_ni) begin
      state_q <= SEQ_IDLE;
      cur_q   <= CH_W'(NCH - 1);
    end else if (load) begin
      state_q <= SEQ_SETTLE;
      cur_q   <= next_ch;
    end else if (fire) begin
      state_q <= SEQ_IDLE;
    end
  end

  seq_capture #(.DATA_W(DATA_W), .CH_W(CH_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_i     (!sync_ni),
    .fire_i     (fire),
    .ch_i       (cur_q),
    .sample_i   (sample_i),
    .ref_ok_i   (ref_ok_i),
    .result_o   (result_o),
    .result_ch_o(result_ch_o),
    .ready_o    (ready_o),
    .noref_o    (noref_o)
  );

  assert_sync_blocks_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_ni |=> !ready_o);

  assert_strobe_from_settle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> $past(state_q == SEQ_SETTLE));

  generate
    if (UNIT_CYCLES > 1) begin : g_width_chk
      assert_strobe_width_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |=> !ready_o);
    end
  endgenerate
endmodule

// File: tb/conv_seq_bench.sv
module conv_seq_bench;
  localparam int UNIT = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sync_ni = 1'b0;
  logic [7:0]  chan_en_i = '0;
  logic [9:0]  settle_word_i = 10'd1;
  logic        ref_ok_i = 1'b1;
  logic [23:0] sample_i = '0;
  logic [23:0] result_o;
  logic [2:0]  result_ch_o;
  logic        ready_o;
  logic        noref_o;

  int n_chk = 0;
  int n_bad = 0;
  bit wd_hit = 1'b0;

  always #5 clk_i = ~clk_i;

  conv_seq u_conv_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_ni(sync_ni), .chan_en_i(chan_en_i),
    .settle_word_i(settle_word_i), .ref_ok_i(ref_ok_i), .sample_i(sample_i),
    .result_o(result_o), .result_ch_o(result_ch_o), .ready_o(ready_o), .noref_o(noref_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_strobe(output int k, input int lim);
    k = 0;
    do begin
      @(negedge clk_i);
      k++;
    end while (!ready_o && k < lim);
  endtask

  task automatic start(input logic [7:0] m, input logic [9:0] w);
    @(negedge clk_i);
    sync_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    chan_en_i = m;
    settle_word_i = w;
    sync_ni = 1'b1;
  endtask

  task automatic t_reset;
    #1;
    chk(ready_o == 0 && noref_o == 0, "R1 flags", {ready_o, noref_o}, 0);
    chk(result_o == 0 && result_ch_o == 0, "R1 result", result_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_rotate;
    int k;
    int exp_ch[5] = '{0, 2, 5, 7, 0};
    start(8'hA5, 10'd1);
    foreach (exp_ch[i]) begin
      sample_i = 24'h010000 + 24'(i);
      wait_strobe(k, 100);
      chk(result_ch_o == 3'(exp_ch[i]), "R2 rotation order", result_ch_o, exp_ch[i]);
      chk(result_o == 24'h010000 + 24'(i), "R5 sample latched", result_o, 24'h010000 + i);
    end
  endtask

  task automatic t_period;
    int k;
    start(8'h01, 10'd3);
    wait_strobe(k, 200);
    chk(k == 3 * UNIT + 1, "R3 first strobe delay", k, 3 * UNIT + 1);
    wait_strobe(k, 200);
    chk(k == 3 * UNIT, "R3 steady period", k, 3 * UNIT);
  endtask

  task automatic t_word_zero;
    int k;
    start(8'h01, 10'd0);
    wait_strobe(k, 200);
    chk(k == UNIT + 1, "R4 word zero as one", k, UNIT + 1);
  endtask

  task automatic t_noref;
    int k;
    ref_ok_i = 1'b0;
    sample_i = 24'h00ABCD;
    start(8'h02, 10'd1);
    wait_strobe(k, 100);
    chk(result_o == 24'hFFFFFF, "R6 saturated result", result_o, 24'hFFFFFF);
    chk(noref_o == 1'b1, "R6 noref set", noref_o, 1);
    chk(result_ch_o == 3'd1, "R5 channel with noref", result_ch_o, 1);
    ref_ok_i = 1'b1;
    sample_i = 24'h123456;
    wait_strobe(k, 100);
    chk(noref_o == 1'b0, "R6 noref cleared", noref_o, 0);
    chk(result_o == 24'h123456, "R6 valid result after", result_o, 24'h123456);
  endtask

  task automatic t_sync_hold;
    int k;
    int seen;
    start(8'h0C, 10'd2);
    wait_strobe(k, 200);
    chk(result_ch_o == 3'd2, "R2 lowest first", result_ch_o, 2);
    @(negedge clk_i);
    sync_ni = 1'b0;
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i);
      if (ready_o) seen++;
    end
    chk(seen == 0, "R7 no strobe in hold", seen, 0);
    sync_ni = 1'b1;
    wait_strobe(k, 200);
    chk(k == 2 * UNIT + 1, "R7 restart delay", k, 2 * UNIT + 1);
    chk(result_ch_o == 3'd2, "R7 restart channel", result_ch_o, 2);
  endtask

  task automatic t_zero_mask;
    int k;
    int seen;
    start(8'h00, 10'd1);
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i);
      if (ready_o) seen++;
    end
    chk(seen == 0, "R8 idle on zero mask", seen, 0);
    chan_en_i = 8'h40;
    wait_strobe(k, 100);
    chk(k == UNIT + 1, "R8 start after mask set", k, UNIT + 1);
    chk(result_ch_o == 3'd6, "R8 channel after mask set", result_ch_o, 6);
  endtask

  task automatic t_mask_change;
    int k;
    start(8'h03, 10'd2);
    wait_strobe(k, 200);
    chk(result_ch_o == 3'd0, "R9 first channel", result_ch_o, 0);
    for (int i = 0; i < 3; i++) @(negedge clk_i);
    chan_en_i = 8'h10;
    wait_strobe(k, 200);
    chk(k + 3 == 2 * UNIT, "R9 interval kept", k + 3, 2 * UNIT);
    chk(result_ch_o == 3'd1, "R9 channel in progress kept", result_ch_o, 1);
    wait_strobe(k, 200);
    chk(result_ch_o == 3'd4, "R9 new mask used", result_ch_o, 4);
    chk(k == 2 * UNIT, "R9 full settle on new channel", k, 2 * UNIT);
  endtask

  task automatic t_single;
    int k;
    start(8'h80, 10'd1);
    for (int i = 0; i < 3; i++) begin
      wait_strobe(k, 100);
      chk(result_ch_o == 3'd7, "R2 single channel repeats", result_ch_o, 7);
      @(negedge clk_i);
      chk(ready_o == 1'b0, "R10 one-cycle strobe", ready_o, 0);
    end
  endtask

  initial begin
    #200000;
    wd_hit = 1'b1;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_rotate();
    t_period();
    t_word_zero();
    t_noref();
    t_sync_hold();
    t_zero_mask();
    t_mask_change();
    t_single();
    if (!wd_hit) begin
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule